// File: doc/BRIEF.md
# Serial Command Decoder for a Tone Synthesizer

This block receives write-only command words from a host over a serial link and turns them into the register set a waveform synthesis core needs. A chip select that is active low frames each word, and its bits arrive most significant first, one bit per serial clock. The two leading bits of each word pick its target. The targets are a control register, two frequency tuning registers that are wider than one word, and two phase offset registers.

A tuning register is wider than one transfer can carry, so it is written in 14-bit halves. A control bit picks how the halves are handled. In split mode each write replaces one half, and a second control bit picks which half. In wide mode the lower half goes into a staging register. The whole 28-bit value is loaded in one cycle when the upper half for the same register arrives. The serial inputs are brought into the system clock domain through a chain of flip-flops and are then sampled on the system clock.

Top module: `dds_cmd_decoder`

## Requirements
- R1: A frame is accepted only when exactly 16 data bits are sampled on falling serial clock edges while chip select is low, first bit = word bit 15. A frame with any other bit count changes no register.
- R2: A word with bits 15:14 = 00 loads bits 13:0 into the control register (bit 13 = wide mode, bit 12 = upper-half select, bit 8 = core hold).
- R3: A word with bits 15:13 = 110 loads bits 11:0 into phase register 0. A word with 111 loads phase register 1. Bit 12 is ignored.
- R4: With control bit 13 clear and bit 12 clear, a word with bits 15:14 = 01 (register 0) or 10 (register 1) replaces tuning bits 13:0 of that register and leaves bits 27:14 unchanged.
- R5: With control bit 13 clear and bit 12 set, such a word replaces tuning bits 27:14 and leaves bits 13:0 unchanged.
- R6: With control bit 13 set, the first tuning word is staged and no register changes. The next tuning word to the same register loads {second[13:0], first[13:0]} in one update.
- R7: A discarded frame (R1) between the two halves in wide mode leaves the staged half pending.
- R8: In wide mode, a tuning word to the other register while a half is pending replaces the staged half and its target. Any control write drops a pending half.
- R9: After reset the control register reads 0x0100 and all tuning and phase registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial clock, idles high, data sampled on its falling edge |
| ser_sel_n | input | 1 | Frame select, active low |
| ser_din | input | 1 | Serial data, most significant bit first |
| ctrl_o | output | 14 | Control register |
| tune0_o | output | 28 | Tuning word 0 |
| tune1_o | output | 28 | Tuning word 1 |
| phase0_o | output | 12 | Phase offset 0 |
| phase1_o | output | 12 | Phase offset 1 |

## Verification
The assertions assume the serial clock and data are slow against the system clock. Each level must last at least three system cycles, so that every edge is seen after synchronization. They also assume the frame select changes only while the serial clock is high. The bench keeps every serial level for three or four system cycles. It raises and lowers the select only with the serial clock idle high, and it leaves idle gaps between frames, so no two edges fall in one synchronized cycle.

// File: rtl/dds_dec_pkg.sv
package dds_dec_pkg;

   localparam int CTL_WIDE_BIT = 13;
   localparam int CTL_HIGH_BIT = 12;
   localparam int CTL_HOLD_BIT = 8;

   typedef enum logic [2:0] {
      DST_CTRL,
      DST_TUNE0,
      DST_TUNE1,
      DST_PHASE0,
      DST_PHASE1
   } dest_e;

   function automatic dest_e dest_of(input logic [2:0] lead);
      case (lead[2:1])
         2'b00:   return DST_CTRL;
         2'b01:   return DST_TUNE0;
         2'b10:   return DST_TUNE1;
         default: return lead[0] ? DST_PHASE1 : DST_PHASE0;
      endcase
   endfunction

endpackage

// File: rtl/dds_dec_sync.sv
module dds_dec_sync #(
   parameter int STAGES = 2,
   parameter int W = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dds_dec_frame.sv
module dds_dec_frame #(
   parameter int WORD_W = 16,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sel_n_s,
   input  logic              din_s,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

   logic              sclk_d, sel_d;
   logic              bit_edge, sel_fall, sel_rise;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] shift_q;

   if (SAMPLE_ON_FALL) begin : g_fall
      assign bit_edge = sclk_d & ~sclk_s;
   end else begin : g_rise
      assign bit_edge = ~sclk_d & sclk_s;
   end

   assign sel_fall = sel_d & ~sel_n_s;
   assign sel_rise = ~sel_d & sel_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b1;
         sel_d   <= 1'b1;
         cnt_q   <= '0;
         shift_q <= '0;
         valid_o <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         sel_d   <= sel_n_s;
         valid_o <= sel_rise && (cnt_q == CNT_FULL);
         if (sel_fall) begin
            cnt_q <= '0;
         end else if (!sel_n_s && bit_edge) begin
            shift_q <= {shift_q[WORD_W-2:0], din_s};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign word_o = shift_q;
endmodule

// File: rtl/dds_dec_regs.sv
module dds_dec_regs
   import dds_dec_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int TUNE_W = 28,
   parameter int PHASE_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_W-1:0]  word_i,
   input  logic               valid_i,
   output logic [WORD_W-3:0]  ctrl_o,
   output logic [TUNE_W-1:0]  tune0_o,
   output logic [TUNE_W-1:0]  tune1_o,
   output logic [PHASE_W-1:0] phase0_o,
   output logic [PHASE_W-1:0] phase1_o
);
   localparam int CTRL_W = WORD_W - 2;
   localparam int HALF_W = TUNE_W / 2;
   localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << CTL_HOLD_BIT;

   dest_e             dest;
   logic [HALF_W-1:0] half_data;
   logic              wide_mode, high_sel;
   logic              pend_q, pend_idx_q;
   logic [HALF_W-1:0] stage_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [TUNE_W-1:0] tune_q [2];
   logic [1:0]        tune_hit;

   assign dest      = dest_of(word_i[WORD_W-1 -: 3]);
   assign half_data = word_i[HALF_W-1:0];
   assign wide_mode = ctrl_q[CTL_WIDE_BIT];
   assign high_sel  = ctrl_q[CTL_HIGH_BIT];
   assign tune_hit[0] = valid_i && (dest == DST_TUNE0);
   assign tune_hit[1] = valid_i && (dest == DST_TUNE1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= CTRL_RST;
         pend_q     <= 1'b0;
         pend_idx_q <= 1'b0;
         stage_q    <= '0;
         phase0_o   <= '0;
         phase1_o   <= '0;
      end else if (valid_i) begin
         case (dest)
            DST_CTRL: begin
               ctrl_q <= word_i[CTRL_W-1:0];
               pend_q <= 1'b0;
            end
            DST_PHASE0: phase0_o <= word_i[PHASE_W-1:0];
            DST_PHASE1: phase1_o <= word_i[PHASE_W-1:0];
            default: begin
               if (wide_mode) begin
                  if (pend_q && (pend_idx_q == (dest == DST_TUNE1))) begin
                     pend_q <= 1'b0;
                  end else begin
                     pend_q     <= 1'b1;
                     pend_idx_q <= (dest == DST_TUNE1);
                     stage_q    <= half_data;
                  end
               end
            end
         endcase
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_tune
      logic completes;
      assign completes = pend_q && (pend_idx_q == 1'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tune_q[g] <= '0;
         end else if (tune_hit[g]) begin
            if (wide_mode) begin
               if (completes) tune_q[g] <= {half_data, stage_q};
            end else if (high_sel) begin
               tune_q[g][TUNE_W-1:HALF_W] <= half_data;
            end else begin
               tune_q[g][HALF_W-1:0] <= half_data;
            end
         end
      end
   end

   assign ctrl_o  = ctrl_q;
   assign tune0_o = tune_q[0];
   assign tune1_o = tune_q[1];
endmodule

// File: rtl/dds_cmd_decoder.sv
module dds_cmd_decoder #(
   parameter int WORD_W = 16,
   parameter int TUNE_W = 28,
   parameter int PHASE_W = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_sel_n,
   input  logic               ser_din,
   output logic [WORD_W-3:0]  ctrl_o,
   output logic [TUNE_W-1:0]  tune0_o,
   output logic [TUNE_W-1:0]  tune1_o,
   output logic [PHASE_W-1:0] phase0_o,
   output logic [PHASE_W-1:0] phase1_o
);
   if (TUNE_W != 2 * (WORD_W - 2)) begin : g_bad_tune
      $error("TUNE_W must be twice the payload of one word");
   end
   if (PHASE_W > WORD_W - 3) begin : g_bad_phase
      $error("PHASE_W exceeds the phase payload");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]        ser_s;
   logic [WORD_W-1:0] frm_word;
   logic              frm_valid;

   dds_dec_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_sel_n, ser_din}),
      .q     (ser_s)
   );

   dds_dec_frame #(.WORD_W(WORD_W), .SAMPLE_ON_FALL(SAMPLE_ON_FALL)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (ser_s[2]),
      .sel_n_s (ser_s[1]),
      .din_s   (ser_s[0]),
      .word_o  (frm_word),
      .valid_o (frm_valid)
   );

   dds_dec_regs #(.WORD_W(WORD_W), .TUNE_W(TUNE_W), .PHASE_W(PHASE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_i   (frm_word),
      .valid_i  (frm_valid),
      .ctrl_o   (ctrl_o),
      .tune0_o  (tune0_o),
      .tune1_o  (tune1_o),
      .phase0_o (phase0_o),
      .phase1_o (phase1_o)
   );
endmodule

// File: rtl/dds_cmd_decoder_chk.sv
module dds_cmd_decoder_chk #(
   parameter int WORD_W = 16,
   parameter int TUNE_W = 28,
   parameter int PHASE_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               word_valid,
   input logic [WORD_W-1:0]  word,
   input logic [WORD_W-3:0]  ctrl_o,
   input logic [TUNE_W-1:0]  tune0_o,
   input logic [TUNE_W-1:0]  tune1_o,
   input logic [PHASE_W-1:0] phase0_o,
   input logic [PHASE_W-1:0] phase1_o
);
   localparam int HALF_W = TUNE_W / 2;

   assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word[WORD_W-1 -: 2] == 2'b00) |=> ctrl_o == $past(word[WORD_W-3:0]));

   assert_phase0_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase0_o) |-> ($past(word_valid) && $past(word[WORD_W-1 -: 3]) == 3'b110));

   assert_phase1_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase1_o) |-> ($past(word_valid) && $past(word[WORD_W-1 -: 3]) == 3'b111));

   assert_high_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word[WORD_W-1 -: 2] == 2'b01 && !ctrl_o[13] && ctrl_o[12])
      |=> (tune0_o[HALF_W-1:0] == $past(tune0_o[HALF_W-1:0]))
          && (tune0_o[TUNE_W-1:HALF_W] == $past(word[HALF_W-1:0])));

   assert_tune0_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tune0_o) |-> ($past(word_valid) && $past(word[WORD_W-1 -: 2]) == 2'b01));

   assert_tune1_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tune1_o) |-> ($past(word_valid) && $past(word[WORD_W-1 -: 2]) == 2'b10));
endmodule

bind dds_cmd_decoder dds_cmd_decoder_chk #(
   .WORD_W(WORD_W), .TUNE_W(TUNE_W), .PHASE_W(PHASE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_valid (frm_valid),
   .word       (frm_word),
   .ctrl_o     (ctrl_o),
   .tune0_o    (tune0_o),
   .tune1_o    (tune1_o),
   .phase0_o   (phase0_o),
   .phase1_o   (phase1_o)
);

// File: tb/dds_cmd_decoder_bench.sv
`timescale 1ns/1ps
module dds_cmd_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b1;
   logic        ser_sel_n = 1'b1;
   logic        ser_din = 1'b0;
   logic [13:0] ctrl_o;
   logic [27:0] tune0_o, tune1_o;
   logic [11:0] phase0_o, phase1_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [13:0] m_ctrl;
   logic [27:0] m_tune [2];
   logic [11:0] m_ph [2];
   logic        m_pend;
   int          m_pidx;
   logic [13:0] m_stage;

   always #5 clk = ~clk;

   dds_cmd_decoder u_dds_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
      .ser_din(ser_din), .ctrl_o(ctrl_o), .tune0_o(tune0_o), .tune1_o(tune1_o),
      .phase0_o(phase0_o), .phase1_o(phase1_o)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] d, input int n);
      @(negedge clk) ser_sel_n = 1'b0;
      wait_clk(3);
      for (int i = n - 1; i >= 0; i--) begin
         ser_din = d[i];
         wait_clk(3);
         ser_clk = 1'b0;
         wait_clk(3);
         ser_clk = 1'b1;
         wait_clk(1);
      end
      wait_clk(3);
      ser_sel_n = 1'b1;
      wait_clk(8);
   endtask

   // Expected register state, updated from the requirements
   task automatic model_word(input logic [15:0] w);
      int idx;
      case (w[15:14])
         2'b00: begin m_ctrl = w[13:0]; m_pend = 1'b0; end
         2'b11: m_ph[w[13] ? 1 : 0] = w[11:0];
         default: begin
            idx = (w[15:14] == 2'b10) ? 1 : 0;
            if (m_ctrl[13]) begin
               if (m_pend && m_pidx == idx) begin
                  m_tune[idx] = {w[13:0], m_stage};
                  m_pend = 1'b0;
               end else begin
                  m_stage = w[13:0]; m_pend = 1'b1; m_pidx = idx;
               end
            end else if (m_ctrl[12]) m_tune[idx][27:14] = w[13:0];
            else                     m_tune[idx][13:0]  = w[13:0];
         end
      endcase
   endtask

   task automatic check_all(input string tag);
      logic [93:0] act, exp;
      act = {ctrl_o, tune0_o, tune1_o, phase0_o, phase1_o};
      exp = {m_ctrl, m_tune[0], m_tune[1], m_ph[0], m_ph[1]};
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send_word(input logic [15:0] w, input string tag);
      send_bits({16'h0, w}, 16);
      model_word(w);
      check_all(tag);
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      m_ctrl = 14'h0100; m_tune[0] = '0; m_tune[1] = '0;
      m_ph[0] = '0; m_ph[1] = '0; m_pend = 1'b0; m_pidx = 0; m_stage = '0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      check_all("R9 reset values");

      // R2: control words
      send_word(16'h3FFF, "R2 ctrl all ones");
      send_word(16'h2A55, "R2 ctrl pattern");
      send_word(16'h1234, "R2 ctrl pattern b");
      send_word(16'h0000, "R2 ctrl zero");

      // R1: short and long frames are dropped
      send_bits(32'h0000_3ABC >> 1, 15); check_all("R1 15-bit frame ignored");
      send_bits(32'h0001_3ABC, 17);      check_all("R1 17-bit frame ignored");
      send_bits(32'h0, 0);               check_all("R1 empty frame ignored");

      // R3: phase sweep, bit 12 toggled
      for (int v = 0; v < 4096; v += 97) begin
         send_word({3'b110, v[0], v[11:0]}, "R3 phase0");
         send_word({3'b111, v[1], 12'(4095 - v)}, "R3 phase1");
      end

      // R4: split mode, lower half
      for (int v = 0; v < 16384; v += 331) begin
         send_word({2'b01, v[13:0]}, "R4 tune0 low half");
         send_word({2'b10, 14'(16383 - v)}, "R4 tune1 low half");
      end

      // R5: split mode, upper half
      send_word(16'h1000, "R5 select upper half");
      for (int v = 7; v < 16384; v += 331) begin
         send_word({2'b01, 14'(v * 3)}, "R5 tune0 high half");
         send_word({2'b10, v[13:0]}, "R5 tune1 high half");
      end

      // R6: wide mode pairs
      send_word(16'h2000, "R6 enter wide mode");
      for (int k = 0; k < 12; k++) begin
         send_word({(k[0] ? 2'b10 : 2'b01), 14'(k * 1371 + 5)}, "R6 first half staged");
         send_word({(k[0] ? 2'b10 : 2'b01), 14'(16000 - k * 977)}, "R6 second half loads");
      end
      send_word({2'b01, 14'h3FFF}, "R6 staged ones");
      send_word({2'b01, 14'h3FFF}, "R6 full word ones");

      // R7: bad frames between halves
      send_word({2'b10, 14'h0AAA}, "R7 first half");
      send_bits(32'h0000_8123 >> 1, 15); check_all("R7 short frame between halves");
      send_bits(32'h0001_8123, 17);      check_all("R7 long frame between halves");
      send_word({2'b10, 14'h1555}, "R7 pending half survives");

      // R8: retarget and control drop
      send_word({2'b01, 14'h0111}, "R8 half to tune0");
      send_word({2'b10, 14'h0222}, "R8 retarget to tune1");
      send_word({2'b10, 14'h0333}, "R8 tune1 completes");
      send_word({2'b01, 14'h0444}, "R8 staged before ctrl");
      send_word(16'h2000, "R8 ctrl write drops half");
      send_word({2'b01, 14'h0555}, "R8 new first half");
      send_word({2'b01, 14'h0666}, "R8 new pair completes");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule